// File: doc/BRIEF.md
# Debug Mailbox with Cross-Port Handshake Flags

This block is a small two-sided mailbox. One side is reached by an external debug probe, the other by the on-chip processor bus. It gives firmware a polled console or trace path that needs no extra pins and no serial line. Two 32-bit data slots are held inside. Either side may write a slot, and each slot carries a dirty flag. A write sets the flag. The flag clears only when the side that did not write the slot reads it. Both sides can therefore poll one status word to tell when fresh data has arrived and when the previous value has been consumed.

The status word reports the two flags and a debugger-present indication. The debugger-present indication comes from an external pin that is brought into the clock domain through two flops. When the device is locked, the two slots and the status word stay open to the debug side. Debug accesses to any other address are refused, and the refusal is flagged on a dedicated output. Each port has an address, a read strobe, a write strobe and data buses. Read data arrives one cycle after the read strobe.

Top module: `dbg_mailbox`

## Requirements
- R1: After the active-low synchronous reset, both slots hold zero, both flags are clear, both read buses are zero and `dp_deny_o` is low.
- R2: A write on either port to address 0 or 1 stores the 32-bit value in that slot and sets that slot's flag. The other slot's data and flag are unchanged.
- R3: A read of a slot from the port that did not last write it clears the slot's flag. A read from the port that wrote it returns the data and leaves the flag set.
- R4: A write to a slot whose flag is already set replaces the data, and the flag stays set.
- R5: Reading address 2 on either port returns the status word. Bit 0 is the slot-0 flag, bit 1 is the slot-1 flag and bit 2 is the debugger-present pin after two synchronising flops. All other bits are zero. A pin change shows in a status read issued two cycles after the cycle in which the pin changed.
- R6: Read data appears on a port's read bus exactly one cycle after its read strobe. In any cycle that follows no read, the bus is zero. A port may assert read and write together, and the read then returns the value held before the write.
- R7: A write from one port in the same cycle as a read of the same slot from the other port gives the reader the old value. The slot then holds the new value with its flag set.
- R8: When both ports write the same slot in the same cycle, the debug-port value is kept and the slot counts as written by the debug port. A later processor-port read clears the flag.
- R9: While `lock_i` is high, debug accesses to addresses 0 to 2 behave exactly as when unlocked. A debug access to addresses 3 to 7 raises `dp_deny_o` for one cycle, one cycle after the access. `dp_deny_o` stays low while unlocked.
- R10: Addresses 3 to 7 read as zero on both ports, and writes to them change no slot and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Device security lock active |
| dbg_present_i | input | 1 | Asynchronous debugger-attached pin |
| dp_addr_i | input | 3 | Debug-side address (0, 1 slots; 2 status) |
| dp_rd_i | input | 1 | Debug-side read strobe |
| dp_wr_i | input | 1 | Debug-side write strobe |
| dp_wdata_i | input | 32 | Debug-side write data |
| dp_rdata_o | output | 32 | Debug-side read data, one cycle after the strobe |
| dp_deny_o | output | 1 | Debug access refused by the lock |
| cp_addr_i | input | 3 | Processor-side address |
| cp_rd_i | input | 1 | Processor-side read strobe |
| cp_wr_i | input | 1 | Processor-side write strobe |
| cp_wdata_i | input | 32 | Processor-side write data |
| cp_rdata_o | output | 32 | Processor-side read data, one cycle after the strobe |

## Verification
A flag that is wrong inside the block shows at the next status read on either port, one cycle after that read is issued. It can therefore be seen within two cycles of the faulty update. A wrong record of which side last wrote a slot stays hidden until the other side reads that slot. It then shows as a flag that stays set, or one that clears, on the status read that follows. Corrupt slot data or a misrouted write shows one cycle after the next read of that slot. The bench sweeps every combination of slot, writing side and reading side. After each access it reads the status word back, so that each of these faults surfaces within a few cycles of its cause.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Which port last wrote a slot.
  typedef enum logic {
    SIDE_DBG = 1'b0,
    SIDE_CPU = 1'b1
  } side_e;

  // Next value of a dirty flag: a write wins over a clearing read.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  // A read clears the flag only when it comes from the side that did not write.
  function automatic logic read_clears(input side_e writer, input logic dbg_rd, input logic cpu_rd);
    return ((writer == SIDE_DBG) && cpu_rd) || ((writer == SIDE_CPU) && dbg_rd);
  endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_wr,
  input  logic          cpu_wr,
  input  logic          dbg_rd,
  input  logic          cpu_rd,
  input  logic [DW-1:0] dbg_wdata,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] data,
  output logic          dirty
);
  side_e writer;
  logic  set_ev;
  logic  clr_ev;

  assign set_ev = dbg_wr | cpu_wr;
  assign clr_ev = read_clears(writer, dbg_rd, cpu_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data   <= '0;
      dirty  <= 1'b0;
      writer <= SIDE_DBG;
    end else begin
      if (set_ev) begin
        data   <= dbg_wr ? dbg_wdata : cpu_wdata;
        writer <= dbg_wr ? SIDE_DBG : SIDE_CPU;
      end
      dirty <= flag_next(dirty, set_ev, clr_ev);
    end
  end

  // R2 / R4 / R7: any write leaves the flag set
  p_write_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr || cpu_wr) |=> dirty);

  // R8: debug value kept on a write collision
  p_dbg_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr |=> (data == $past(dbg_wdata)));

  p_cpu_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !dbg_wr) |=> (data == $past(cpu_wdata)));

  p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_wr || cpu_wr) |=> $stable(data));

  // R3: with no traffic the flag holds; a clear always follows a read
  p_keep_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty && !dbg_wr && !cpu_wr && !dbg_rd && !cpu_rd) |=> dirty);

  p_clear_by_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dirty) |-> $past(dbg_rd || cpu_rd));

endmodule

// File: rtl/mbx_rport.sv
module mbx_rport #(
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 3,
  parameter int unsigned NCH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ch_data [NCH],
  input  logic [DW-1:0] status,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NCH);

  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) sel = ch_data[i];
    end
    if (addr == STAT_ADDR) sel = status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
    else         rdata <= '0;
  end

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == '0));

  p_hole_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr > STAT_ADDR)) |=> (rdata == '0));

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 3,
  parameter int unsigned NCH     = 2,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_i,
  input  logic          dbg_present_i,
  input  logic [AW-1:0] dp_addr_i,
  input  logic          dp_rd_i,
  input  logic          dp_wr_i,
  input  logic [DW-1:0] dp_wdata_i,
  output logic [DW-1:0] dp_rdata_o,
  output logic          dp_deny_o,
  input  logic [AW-1:0] cp_addr_i,
  input  logic          cp_rd_i,
  input  logic          cp_wr_i,
  input  logic [DW-1:0] cp_wdata_i,
  output logic [DW-1:0] cp_rdata_o
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NCH);

  logic [DW-1:0]  ch_data [NCH];
  logic [NCH-1:0] ch_dirty;
  logic           present_sync;
  logic [DW-1:0]  status_word;
  logic           dp_outside;

  mbx_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (dbg_present_i),
    .q_o   (present_sync)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mbx_channel #(.DW(DW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .dbg_wr    (dp_wr_i && (dp_addr_i == AW'(g))),
      .cpu_wr    (cp_wr_i && (cp_addr_i == AW'(g))),
      .dbg_rd    (dp_rd_i && (dp_addr_i == AW'(g))),
      .cpu_rd    (cp_rd_i && (cp_addr_i == AW'(g))),
      .dbg_wdata (dp_wdata_i),
      .cpu_wdata (cp_wdata_i),
      .data      (ch_data[g]),
      .dirty     (ch_dirty[g])
    );
  end

  always_comb begin
    status_word          = '0;
    status_word[NCH-1:0] = ch_dirty;
    status_word[NCH]     = present_sync;
  end

  mbx_rport #(.DW(DW), .AW(AW), .NCH(NCH)) u_dp_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (dp_rd_i),
    .addr    (dp_addr_i),
    .ch_data (ch_data),
    .status  (status_word),
    .rdata   (dp_rdata_o)
  );

  mbx_rport #(.DW(DW), .AW(AW), .NCH(NCH)) u_cp_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (cp_rd_i),
    .addr    (cp_addr_i),
    .ch_data (ch_data),
    .status  (status_word),
    .rdata   (cp_rdata_o)
  );

  // Lock gating: the mailbox window stays open, everything beyond it is refused.
  assign dp_outside = (dp_rd_i || dp_wr_i) && (dp_addr_i > STAT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) dp_deny_o <= 1'b0;
    else        dp_deny_o <= lock_i && dp_outside;
  end

  p_deny_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dp_deny_o |-> $past(lock_i));

  p_window_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dp_rd_i || dp_wr_i) && (dp_addr_i <= STAT_ADDR)) |=> !dp_deny_o);

  p_deny_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && (dp_rd_i || dp_wr_i) && (dp_addr_i > STAT_ADDR)) |=> dp_deny_o);

endmodule

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_i = 1'b0;
  logic        dbg_present_i = 1'b0;
  logic [2:0]  dp_addr_i = '0;
  logic        dp_rd_i = 1'b0;
  logic        dp_wr_i = 1'b0;
  logic [31:0] dp_wdata_i = '0;
  logic [31:0] dp_rdata_o;
  logic        dp_deny_o;
  logic [2:0]  cp_addr_i = '0;
  logic        cp_rd_i = 1'b0;
  logic        cp_wr_i = 1'b0;
  logic [31:0] cp_wdata_i = '0;
  logic [31:0] cp_rdata_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Bench view of the mailbox, written from the requirements.
  logic [31:0] m_data [2];
  bit          m_flag [2];
  bit          m_cpu_wrote [2];
  bit          m_s1, m_s2;

  always #2.5 clk = ~clk;

  dbg_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .dbg_present_i(dbg_present_i),
    .dp_addr_i(dp_addr_i), .dp_rd_i(dp_rd_i), .dp_wr_i(dp_wr_i),
    .dp_wdata_i(dp_wdata_i), .dp_rdata_o(dp_rdata_o), .dp_deny_o(dp_deny_o),
    .cp_addr_i(cp_addr_i), .cp_rd_i(cp_rd_i), .cp_wr_i(cp_wr_i),
    .cp_wdata_i(cp_wdata_i), .cp_rdata_o(cp_rdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [2:0] a);
    if (a < 3'd2)       return m_data[a[0]];
    else if (a == 3'd2) return {29'd0, m_s2, m_flag[1], m_flag[0]};
    else                return 32'd0;
  endfunction

  // One cycle of traffic on both ports; checks both read buses and the deny pulse.
  task automatic step(input string tag,
                      input bit drd, input bit dwr, input logic [2:0] da, input logic [31:0] dd,
                      input bit crd, input bit cwr, input logic [2:0] ca, input logic [31:0] cd);
    logic [31:0] exp_d, exp_c;
    bit          exp_deny;
    exp_d    = drd ? mread(da) : 32'd0;
    exp_c    = crd ? mread(ca) : 32'd0;
    exp_deny = lock_i && (drd || dwr) && (da > 3'd2);
    dp_rd_i = drd; dp_wr_i = dwr; dp_addr_i = da; dp_wdata_i = dd;
    cp_rd_i = crd; cp_wr_i = cwr; cp_addr_i = ca; cp_wdata_i = cd;
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      bit dw, cw, dr, cr;
      dw = dwr && (da == 3'(c));
      cw = cwr && (ca == 3'(c));
      dr = drd && (da == 3'(c));
      cr = crd && (ca == 3'(c));
      if (dw || cw) begin
        m_data[c]      = dw ? dd : cd;
        m_flag[c]      = 1'b1;
        m_cpu_wrote[c] = !dw;
      end else if ((m_cpu_wrote[c] && dr) || (!m_cpu_wrote[c] && cr)) begin
        m_flag[c] = 1'b0;
      end
    end
    m_s2 = m_s1;
    m_s1 = dbg_present_i;
    @(negedge clk);
    dp_rd_i = 0; dp_wr_i = 0; dp_addr_i = '0; dp_wdata_i = '0;
    cp_rd_i = 0; cp_wr_i = 0; cp_addr_i = '0; cp_wdata_i = '0;
    chk({tag, " dp_rdata"}, dp_rdata_o, exp_d);
    chk({tag, " cp_rdata"}, cp_rdata_o, exp_c);
    chk({tag, " dp_deny"}, {31'd0, dp_deny_o}, {31'd0, exp_deny});
  endtask

  task automatic wr_side(input string tag, input bit cpu, input logic [2:0] a, input logic [31:0] v);
    if (cpu) step(tag, 0, 0, 3'd0, 32'd0, 0, 1, a, v);
    else     step(tag, 0, 1, a, v, 0, 0, 3'd0, 32'd0);
  endtask

  task automatic rd_side(input string tag, input bit cpu, input logic [2:0] a);
    if (cpu) step(tag, 0, 0, 3'd0, 32'd0, 1, 0, a, 32'd0);
    else     step(tag, 1, 0, a, 32'd0, 0, 0, 3'd0, 32'd0);
  endtask

  // Status read on both ports at once.
  task automatic status_both(input string tag);
    step(tag, 1, 0, 3'd2, 32'd0, 1, 0, 3'd2, 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_data[c] = '0; m_flag[c] = 0; m_cpu_wrote[c] = 0;
    end
    m_s1 = 0; m_s2 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at the ports
    chk("R1 dp_rdata after reset", dp_rdata_o, 32'd0);
    chk("R1 cp_rdata after reset", cp_rdata_o, 32'd0);
    chk("R1 deny after reset", {31'd0, dp_deny_o}, 32'd0);
    step("R1 slot reads", 1, 0, 3'd0, 0, 1, 0, 3'd1, 0);
    status_both("R1 status");

    // R2 / R3 / R5: every slot x writing side x reading side
    for (int k = 0; k < 8; k++) begin
      bit c, w, r;
      logic [31:0] v;
      c = k[2]; w = k[1]; r = k[0];
      v = 32'hA5A5_0000 + 32'(k) * 32'h0001_0203 + 32'(k);
      wr_side("R2 write", w, {2'b00, c}, v);
      status_both("R5 status after write");
      rd_side("R3 read", r, {2'b00, c});
      status_both("R3 flag after read");
      rd_side("R3 second read", !w, {2'b00, c});
      status_both("R3 flag settled");
    end

    // R4: overwrite while dirty
    wr_side("R4 first write", 1, 3'd1, 32'h1111_2222);
    wr_side("R4 overwrite", 1, 3'd1, 32'h3333_4444);
    status_both("R4 flag still set");
    rd_side("R4 newest data", 0, 3'd1);
    status_both("R4 cleared by debug read");

    // R7: read old / write new on opposite ports, same slot, same cycle
    step("R7 dbg read vs cpu write", 1, 0, 3'd0, 0, 0, 1, 3'd0, 32'hDEAD_0007);
    status_both("R7 flag set");
    step("R7 cpu read vs dbg write", 0, 1, 3'd1, 32'hBEEF_0070, 1, 0, 3'd1, 0);
    status_both("R7 flag set slot1");
    rd_side("R7 new value held", 1, 3'd1);

    // R8: write collision, debug value wins and counts as debug-written
    step("R8 both write", 0, 1, 3'd0, 32'h0D0D_0008, 0, 1, 3'd0, 32'h0C0C_0008);
    rd_side("R8 debug read keeps flag", 0, 3'd0);
    status_both("R8 flag after same-side read");
    rd_side("R8 cpu read", 1, 3'd0);
    status_both("R8 flag cleared by cpu");

    // R6: idle cycle gives zero, read+write on one port returns the old value
    step("R6 idle", 0, 0, 3'd0, 0, 0, 0, 3'd0, 0);
    step("R6 rd+wr same port", 1, 1, 3'd1, 32'h6666_0006, 1, 1, 3'd0, 32'h6060_0006);
    status_both("R6 status after rd+wr");

    // R9 / R10: address sweep, unlocked and locked, reads and writes
    for (int l = 0; l < 2; l++) begin
      lock_i = l[0];
      for (int a = 0; a < 8; a++) begin
        step("R9 debug read sweep", 1, 0, 3'(a), 0, 1, 0, 3'(a), 0);
      end
      for (int a = 3; a < 8; a++) begin
        step("R10 hole write", 0, 1, 3'(a), 32'hFFFF_FFFF, 0, 1, 3'(a), 32'hEEEE_EEEE);
        step("R10 slots untouched", 1, 0, 3'd0, 0, 1, 0, 3'd1, 0);
        status_both("R10 flags untouched");
      end
      wr_side("R9 write while lock state", 0, 3'd0, 32'h9000_0000 + 32'(l));
      rd_side("R9 cpu reads debug data", 1, 3'd0);
    end
    lock_i = 1'b0;

    // R5: debugger-present through two flops
    dbg_present_i = 1'b1;
    status_both("R5 present not yet");
    status_both("R5 present stage two");
    status_both("R5 present visible");
    dbg_present_i = 1'b0;
    status_both("R5 absent not yet");
    status_both("R5 absent stage two");
    status_both("R5 absent visible");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule